// File: doc/BRIEF.md
# Multi-Channel FIFO Bridge Controller

This block is the control plane of a bridge that moves data between memory and a coprocessor through per-channel hardware FIFOs. Channels come in two directions: those that feed the coprocessor and those that drain it. Each channel keeps its own set of configuration registers: a buffer base address, the addresses of its state word, pointer word and lock, a depth, a transfer width, and a running flag. Software writes these registers through a simple write-only register port. It first names a channel with a direction register and an index register. Every later configuration write then goes to that channel.

The block watches the FIFO status flags. A feeding FIFO that has run empty needs a refill from memory. A draining FIFO that has filled up needs to be emptied to memory. Among the running channels that need service, the block picks one in round-robin order. It raises a request to a downstream bus-master engine and presents a copy of that channel's configuration. The engine carries out the five-transaction exchange with memory and then pulses done. Only one request is outstanding at a time. A write to the reset register wipes all configuration, cancels any pending request and pulses a FIFO flush strobe.

Top module: `fifo_chan_ctrl`

## Requirements
- R1: A write to offset 0 clears every channel's configuration (all fields zero, running cleared), sets the selection back to direction 0 / index 0, drops any pending request, resets the round-robin search start to channel 0, and raises `fifo_flush` for exactly the one cycle after the write.
- R2: Offset 1 bit 0 sets the direction (0 = toward the coprocessor, 1 = from the coprocessor) and offset 2 sets the channel index. Writes to offsets 3 (state address), 4 (pointer address), 5 (lock address), 6 (depth), 7 (width), 8 (base address) and 9 (running, bit 0) change only the selected channel.
- R3: A write to offset 2 with a value equal to or above the channel count of the currently selected direction is ignored, and the previous selection stays in force.
- R4: A width write (offset 7) whose two low bits are not both zero is ignored, and the channel keeps its previous width.
- R5: A channel toward the coprocessor needs service when its `to_empty` bit is high. A channel from the coprocessor needs service when its `from_full` bit is high.
- R6: A channel whose running bit is clear is never requested, whatever its FIFO flag.
- R7: Channels are searched in the global order: coprocessor-bound channels 0..N_TO-1, then coprocessor-sourced channels 0..N_FROM-1 (global numbers N_TO..N_TO+N_FROM-1). The search wraps around and starts at the global channel after the one last served.
- R8: When a request is issued, `req_valid` rises on the clock edge that sees the channel eligible. The request outputs carry a copy of the channel's configuration taken at that edge, and they stay unchanged until done, even if software rewrites that channel meanwhile.
- R9: With `req_valid` high, a `req_done` pulse drops `req_valid` at the next edge. A new request can issue no earlier than the edge after that. `req_done` has no effect while no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | DW | Register write data |
| to_empty | input | N_TO | Empty flags of the coprocessor-bound FIFOs |
| from_full | input | N_FROM | Full flags of the coprocessor-sourced FIFOs |
| fifo_flush | output | 1 | One-cycle flush strobe to all FIFOs |
| req_valid | output | 1 | Transfer request pending |
| req_done | input | 1 | Engine finished the pending transfer |
| req_dir | output | 1 | Direction of the requested channel (1 = from coprocessor) |
| req_chan | output | GW | Index of the requested channel within its direction |
| req_state_addr | output | AW | State word address of the requested channel |
| req_ptr_addr | output | AW | Pointer word address of the requested channel |
| req_lock_addr | output | AW | Lock address of the requested channel |
| req_base | output | AW | Data buffer base address of the requested channel |
| req_depth | output | DW | Depth of the requested channel |
| req_width | output | DW | Transfer width in bytes of the requested channel |

## Verification
The scheduler is tried with three channels raised in the same cycle, which shows the search order from a fresh pointer. Two later mixed sets, raised after the pointer has moved past the highest served channel, show that the search wraps around and starts after the last channel served, not at channel zero. Some patterns raise a flag on a stopped channel, or write an out-of-range index or a misaligned width. In these the grant data shows whether the write was ignored or went to the wrong channel. Other patterns rewrite a channel while its transfer is pending, pulse done while nothing is pending, and issue a reset write during a transfer. These show the difference between a live configuration view and a snapshot, and whether stray done pulses or a cancelled transfer disturb later scheduling.

// File: rtl/fifo_chan_ctrl.sv
module fifo_chan_ctrl #(
  parameter int N_TO   = 4,
  parameter int N_FROM = 4,
  parameter int AW     = 32,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [N_TO-1:0]   to_empty,
  input  logic [N_FROM-1:0] from_full,
  output logic              fifo_flush,
  output logic              req_valid,
  input  logic              req_done,
  output logic              req_dir,
  output logic [$clog2(N_TO+N_FROM)-1:0] req_chan,
  output logic [AW-1:0]     req_state_addr,
  output logic [AW-1:0]     req_ptr_addr,
  output logic [AW-1:0]     req_lock_addr,
  output logic [AW-1:0]     req_base,
  output logic [DW-1:0]     req_depth,
  output logic [DW-1:0]     req_width
);
  localparam int NCH = N_TO + N_FROM;
  localparam int GW  = $clog2(NCH);

  logic          sel_dir;
  logic [GW-1:0] sel_idx;
  logic [AW-1:0] st_a [NCH];
  logic [AW-1:0] pt_a [NCH];
  logic [AW-1:0] lk_a [NCH];
  logic [AW-1:0] bs_a [NCH];
  logic [DW-1:0] dp   [NCH];
  logic [DW-1:0] wd   [NCH];
  logic [NCH-1:0] run;
  logic [GW-1:0] rr, grant, pick;
  logic          pick_ok;

  wire           wr_rst  = reg_wr && reg_addr == 4'd0;
  wire  [DW-1:0] sel_lim = sel_dir ? DW'(N_FROM) : DW'(N_TO);
  wire           sel_ok  = DW'(sel_idx) < sel_lim;
  wire  [GW-1:0] sel_g   = sel_dir ? sel_idx + GW'(N_TO) : sel_idx;
  wire [NCH-1:0] elig    = {from_full, to_empty} & run;

  assign req_dir  = grant >= GW'(N_TO);
  assign req_chan = req_dir ? grant - GW'(N_TO) : grant;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_dir <= 1'b0;
      sel_idx <= '0;
    end else if (wr_rst) begin
      sel_dir <= 1'b0;
      sel_idx <= '0;
    end else if (reg_wr && reg_addr == 4'd1) begin
      sel_dir <= reg_wdata[0];
    end else if (reg_wr && reg_addr == 4'd2 && reg_wdata < sel_lim) begin
      sel_idx <= GW'(reg_wdata);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run <= '0;
      for (int c = 0; c < NCH; c++) begin
        st_a[c] <= '0; pt_a[c] <= '0; lk_a[c] <= '0;
        bs_a[c] <= '0; dp[c] <= '0; wd[c] <= '0;
      end
    end else if (wr_rst) begin
      run <= '0;
      for (int c = 0; c < NCH; c++) begin
        st_a[c] <= '0; pt_a[c] <= '0; lk_a[c] <= '0;
        bs_a[c] <= '0; dp[c] <= '0; wd[c] <= '0;
      end
    end else if (reg_wr && sel_ok) begin
      case (reg_addr)
        4'd3: st_a[sel_g] <= AW'(reg_wdata);
        4'd4: pt_a[sel_g] <= AW'(reg_wdata);
        4'd5: lk_a[sel_g] <= AW'(reg_wdata);
        4'd6: dp[sel_g]   <= reg_wdata;
        4'd7: if (reg_wdata[1:0] == 2'b00) wd[sel_g] <= reg_wdata;
        4'd8: bs_a[sel_g] <= AW'(reg_wdata);
        4'd9: run[sel_g]  <= reg_wdata[0];
        default: ;
      endcase
    end

  always_comb begin
    logic [GW:0] c;
    pick_ok = 1'b0;
    pick    = '0;
    for (int k = 0; k < NCH; k++) begin
      c = {1'b0, rr} + (GW+1)'(k);
      if (c >= (GW+1)'(NCH)) c = c - (GW+1)'(NCH);
      if (!pick_ok && elig[c[GW-1:0]]) begin
        pick_ok = 1'b1;
        pick    = c[GW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fifo_flush <= 1'b0;
    else        fifo_flush <= wr_rst;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_valid <= 1'b0;
      rr        <= '0;
      grant     <= '0;
    end else if (wr_rst) begin
      req_valid <= 1'b0;
      rr        <= '0;
    end else if (req_valid) begin
      if (req_done) begin
        req_valid <= 1'b0;
        rr        <= (grant == GW'(NCH-1)) ? '0 : grant + 1'b1;
      end
    end else if (pick_ok) begin
      req_valid <= 1'b1;
      grant     <= pick;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_state_addr <= '0; req_ptr_addr <= '0; req_lock_addr <= '0;
      req_base <= '0; req_depth <= '0; req_width <= '0;
    end else if (!req_valid && pick_ok && !wr_rst) begin
      req_state_addr <= st_a[pick];
      req_ptr_addr   <= pt_a[pick];
      req_lock_addr  <= lk_a[pick];
      req_base       <= bs_a[pick];
      req_depth      <= dp[pick];
      req_width      <= wd[pick];
    end
endmodule

// File: rtl/fifo_chan_ctrl_chk.sv
module fifo_chan_ctrl_chk #(
  parameter int N_TO   = 4,
  parameter int N_FROM = 4,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int GW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [3:0]        reg_addr,
  input logic [N_TO-1:0]   to_empty,
  input logic [N_FROM-1:0] from_full,
  input logic              fifo_flush,
  input logic              req_valid,
  input logic              req_done,
  input logic              req_dir,
  input logic [GW-1:0]     req_chan,
  input logic [AW-1:0]     req_base,
  input logic [DW-1:0]     req_width
);
  wire rst_wr = reg_wr && reg_addr == 4'd0;

  assert_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> fifo_flush && !req_valid);

  assert_width_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_width[1:0] == 2'b00);

  assert_to_side_need_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !req_dir |-> ($past(to_empty) & (N_TO'(1) << req_chan)) != '0);

  assert_from_side_need_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_dir |-> ($past(from_full) & (N_FROM'(1) << req_chan)) != '0);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done && !rst_wr |=>
      req_valid && $stable(req_dir) && $stable(req_chan) && $stable(req_base) && $stable(req_width));

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_done |=> !req_valid);
endmodule

bind fifo_chan_ctrl fifo_chan_ctrl_chk #(
  .N_TO(N_TO), .N_FROM(N_FROM), .AW(AW), .DW(DW), .GW($clog2(N_TO+N_FROM))
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .to_empty(to_empty), .from_full(from_full), .fifo_flush(fifo_flush),
  .req_valid(req_valid), .req_done(req_done), .req_dir(req_dir),
  .req_chan(req_chan), .req_base(req_base), .req_width(req_width)
);

// File: tb/fifo_chan_ctrl_tb_top.sv
`timescale 1ns/1ps
module fifo_chan_ctrl_tb_top;
  localparam int N_TO = 4, N_FROM = 4, GW = 3;

  typedef struct {
    bit          dir;
    int          chan;
    logic [31:0] base, width, st, pt, lk, dp;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [N_TO-1:0] te_on = 0, te_off = 0;
  logic [N_FROM-1:0] ff_on = 0, ff_off = 0;
  logic eng_done = 0, poke_done = 0;
  wire [N_TO-1:0] to_empty = te_on ^ te_off;
  wire [N_FROM-1:0] from_full = ff_on ^ ff_off;
  wire req_done = eng_done | poke_done;
  logic fifo_flush, req_valid, req_dir;
  logic [GW-1:0] req_chan;
  logic [31:0] req_state_addr, req_ptr_addr, req_lock_addr, req_base, req_depth, req_width;

  int nchk = 0, nfail = 0, hold_len = 2, hold = 0;
  bit busy = 0;
  item_t q[$];
  item_t cur;

  always #4 clk = ~clk;

  fifo_chan_ctrl #(.N_TO(N_TO), .N_FROM(N_FROM), .AW(32), .DW(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .to_empty(to_empty), .from_full(from_full), .fifo_flush(fifo_flush),
    .req_valid(req_valid), .req_done(req_done), .req_dir(req_dir), .req_chan(req_chan),
    .req_state_addr(req_state_addr), .req_ptr_addr(req_ptr_addr), .req_lock_addr(req_lock_addr),
    .req_base(req_base), .req_depth(req_depth), .req_width(req_width));

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(item_t e, string tag);
    chk(req_dir == e.dir, tag, "dir", 32'(req_dir), 32'(e.dir));
    chk(int'(req_chan) == e.chan, tag, "chan", 32'(req_chan), 32'(e.chan));
    chk(req_base == e.base, tag, "base", req_base, e.base);
    chk(req_width == e.width, tag, "width", req_width, e.width);
    chk(req_state_addr == e.st, tag, "state", req_state_addr, e.st);
    chk(req_ptr_addr == e.pt, tag, "ptr", req_ptr_addr, e.pt);
    chk(req_lock_addr == e.lk, tag, "lock", req_lock_addr, e.lk);
    chk(req_depth == e.dp, tag, "depth", req_depth, e.dp);
  endtask

  function automatic item_t mk(bit d, int i, logic [31:0] b, logic [31:0] w);
    item_t it;
    it.dir = d; it.chan = i; it.base = b; it.width = w;
    it.st = b + 32'h10; it.pt = b + 32'h20; it.lk = b + 32'h30;
    it.dp = 32'(8 + i + (d ? 4 : 0));
    return it;
  endfunction

  // monitor / engine model: pops expected grants, answers with done
  always begin
    @(negedge clk);
    if (eng_done) begin
      eng_done = 0;
      busy = 0;
      chk(req_valid == 0, "R9", "valid after done", 32'(req_valid), 0);
    end else if (busy && !req_valid) begin
      busy = 0;
    end else if (busy) begin
      cmp(cur, "R8");
      hold++;
      if (hold >= hold_len) begin
        eng_done = 1;
        if (cur.dir) ff_off[cur.chan] = ~ff_off[cur.chan];
        else         te_off[cur.chan] = ~te_off[cur.chan];
      end
    end else if (req_valid) begin
      if (q.size() == 0) begin
        chk(0, "R6 R7", "unexpected request chan", 32'(req_chan), 32'hffff_ffff);
        busy = 1; hold = 0;
        cur.dir = req_dir; cur.chan = int'(req_chan);
      end else begin
        cur = q.pop_front();
        cmp(cur, "R5 R7");
        busy = 1; hold = 0;
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic cfg(item_t it, bit running);
    wr(1, 32'(it.dir)); wr(2, 32'(it.chan));
    wr(3, it.st); wr(4, it.pt); wr(5, it.lk); wr(6, it.dp);
    wr(7, it.width); wr(8, it.base); wr(9, 32'(running));
  endtask

  task automatic push(item_t it);
    q.push_back(it);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || busy || req_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_valid();
    while (!req_valid) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    item_t it;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_valid == 0, "R1", "reset valid", 32'(req_valid), 0);
    chk(fifo_flush == 0, "R1", "reset flush", 32'(fifo_flush), 0);

    // nothing running: flags alone raise nothing
    te_on = ~te_on; ff_on = ~ff_on;
    repeat (10) @(negedge clk);
    chk(req_valid == 0, "R6", "no running channel", 32'(req_valid), 0);
    te_on = ~te_on; ff_on = ~ff_on;
    @(negedge clk);

    cfg(mk(0, 0, 32'hA000, 8), 1);
    cfg(mk(0, 2, 32'hA200, 12), 1);
    cfg(mk(1, 1, 32'hB100, 4), 1);

    // three at once from pointer 0
    push(mk(0, 0, 32'hA000, 8)); push(mk(0, 2, 32'hA200, 12)); push(mk(1, 1, 32'hB100, 4));
    te_on[0] = ~te_on[0]; te_on[2] = ~te_on[2]; ff_on[1] = ~ff_on[1];
    wait_idle();

    // pointer at global 6: wraps to TX0 then RX1
    push(mk(0, 0, 32'hA000, 8)); push(mk(1, 1, 32'hB100, 4));
    te_on[0] = ~te_on[0]; ff_on[1] = ~ff_on[1];
    wait_idle();

    push(mk(0, 2, 32'hA200, 12)); push(mk(1, 1, 32'hB100, 4));
    te_on[2] = ~te_on[2]; ff_on[1] = ~ff_on[1];
    wait_idle();

    // R3: out-of-range index ignored
    it = mk(0, 3, 32'hC300, 16);
    wr(1, 0); wr(2, 3); wr(2, 9); wr(2, 4);
    wr(3, it.st); wr(4, it.pt); wr(5, it.lk); wr(6, it.dp);
    wr(7, it.width); wr(8, it.base); wr(9, 1);
    push(it); te_on[3] = ~te_on[3];
    wait_idle();

    // R4: misaligned width ignored
    wr(7, 6); wr(7, 32'h13);
    push(it); te_on[3] = ~te_on[3];
    wait_idle();

    // R8: rewrite while pending, snapshot held
    hold_len = 10;
    push(mk(0, 0, 32'hA000, 8)); te_on[0] = ~te_on[0];
    wait_valid();
    wr(1, 0); wr(2, 0); wr(8, 32'hD000);
    wait_idle();
    hold_len = 2;

    // R2: new base only on TX0; TX2 untouched; pointer at 1 so TX2 first
    it = mk(0, 0, 32'hA000, 8); it.base = 32'hD000;
    push(mk(0, 2, 32'hA200, 12)); push(it);
    te_on[0] = ~te_on[0]; te_on[2] = ~te_on[2];
    wait_idle();

    // R9: stray done while idle
    poke_done = 1; @(negedge clk); poke_done = 0; @(negedge clk);
    chk(req_valid == 0, "R9", "stray done", 32'(req_valid), 0);
    push(mk(1, 1, 32'hB100, 4)); ff_on[1] = ~ff_on[1];
    wait_idle();

    // R6: stopped channel with flag set
    wr(1, 0); wr(2, 2); wr(9, 0);
    te_on[2] = ~te_on[2];
    repeat (20) @(negedge clk);
    chk(req_valid == 0, "R6", "stopped channel", 32'(req_valid), 0);
    te_on[2] = ~te_on[2];
    @(negedge clk);

    // R1: reset write during a pending transfer
    hold_len = 1000;
    push(it); te_on[0] = ~te_on[0];
    wait_valid();
    @(negedge clk);
    wr(0, 0);
    chk(fifo_flush == 1, "R1", "flush pulse", 32'(fifo_flush), 1);
    chk(req_valid == 0, "R1", "valid cancelled", 32'(req_valid), 0);
    @(negedge clk);
    chk(fifo_flush == 0, "R1", "flush one cycle", 32'(fifo_flush), 0);
    repeat (10) @(negedge clk);
    chk(req_valid == 0, "R1", "running cleared", 32'(req_valid), 0);
    hold_len = 2;
    it.dir = 0; it.chan = 0; it.base = 32'hE000; it.width = 0;
    it.st = 0; it.pt = 0; it.lk = 0; it.dp = 0;
    push(it);
    wr(8, 32'hE000); wr(9, 1);
    wait_idle();
    chk(q.size() == 0, "R1", "grant after reset", 32'(q.size()), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule